// File: doc/BRIEF.md
# Mode-Selectable Bit-Rate Timing Generator

This block derives serial bit timing from the system clock. Software writes an integer divisor N, and a mode input picks one of three fixed prescale factors. The block then produces two timing strobes. The first is an oversampling strobe that fires once every N+1 clocks. The second is a per-bit strobe that fires once every F·(N+1) clocks, where F is 16 in normal asynchronous mode, 8 in double-speed asynchronous mode and 2 in synchronous master mode. The transmitter and receiver of a serial port use these strobes to shift and sample data.

In synchronous master mode the block also drives a square-wave line clock at the bit rate. It toggles on every oversampling strobe, so each half of its period lasts N+1 clocks. In every other mode the line clock is held low.

A write to the divisor takes effect on the next clock edge. The down-counter, the sub-bit phase and the line clock all restart from that edge, so the new rate applies at once. The block has no data stream. All pins are plain control and status signals with no back-pressure, and each strobe is a single-cycle pulse that the consumer must accept in the cycle it appears. Software is expected to set the divisor before it enables the transmitter or receiver.

Top module: `bitrate_gen`

## Requirements
- R1: After reset the divisor is 0 and the line clock is low. The oversample strobe is then high in every cycle, and the bit strobe stays low in the first cycle after reset.
- R2: With a divisor N and no further writes, the oversample strobe is a one-cycle pulse that repeats every N+1 clocks.
- R3: In mode 2'b00 (normal asynchronous) the bit strobe repeats every 16·(N+1) clocks. Mode 2'b11 behaves the same way.
- R4: In mode 2'b01 (double-speed asynchronous) the bit strobe repeats every 8·(N+1) clocks.
- R5: In mode 2'b10 (synchronous master) the bit strobe repeats every 2·(N+1) clocks.
- R6: In mode 2'b10 the line clock inverts after every oversample strobe. It is low right after a divisor write, so its period is 2·(N+1) clocks.
- R7: In any mode other than 2'b10 the line clock is low from the cycle after that mode is applied.
- R8: A write with value N restarts the timing. The first oversample strobe comes N cycles after the write edge, and the first bit strobe comes F·(N+1)−1 cycles after it, counting the first cycle after the edge as cycle 0.
- R9: The bit strobe only fires together with an oversample strobe, and it never fires in two consecutive cycles.
- R10: When the mode changes to a smaller factor and the sub-bit phase is already at or past the new last phase, the bit strobe fires on the next oversample strobe. The phase then wraps to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 normal async (÷16), 01 double-speed (÷8), 10 sync master (÷2), 11 as 00 |
| div_we | input | 1 | Divisor write strobe |
| div_wdata | input | 12 | Divisor value N |
| os_tick | output | 1 | Oversample strobe, every N+1 clocks |
| bit_tick | output | 1 | Bit strobe, every F·(N+1) clocks |
| sclk_out | output | 1 | Generated line clock in sync master mode, low otherwise |

## Verification
The hardest case to reach from the ports is a mode change in the middle of a bit. A switch is only interesting when the sub-bit phase has already gone past the last phase of the new, smaller factor. The bench runs normal mode with a zero divisor for several cycles, so that the phase climbs well above 1. It then switches to synchronous mode without writing the divisor and checks that the bit strobe fires in that same cycle. The other cases restart with a divisor write. The bench measures the first and second bit strobes, and the line clock edges, against the factor of each mode. A behavioural model is compared on every clock.

// File: rtl/brg_pkg.sv
package brg_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC_X16 = 2'b00,
    MODE_ASYNC_X8  = 2'b01,
    MODE_SYNC_X2   = 2'b10,
    MODE_RSVD      = 2'b11
  } brg_mode_e;

  localparam int PHASE_W = 4;

  // last sub-bit phase index for each mode (factor minus one)
  function automatic logic [PHASE_W-1:0] last_phase(brg_mode_e m);
    case (m)
      MODE_ASYNC_X8: last_phase = PHASE_W'(7);
      MODE_SYNC_X2:  last_phase = PHASE_W'(1);
      default:       last_phase = PHASE_W'(15);
    endcase
  endfunction

endpackage

// File: rtl/brg_os_counter.sv
module brg_os_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] period_m1,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load_en)    cnt <= load_val;
    else if (cnt == '0)  cnt <= period_m1;
    else                 cnt <= cnt - CNT_W'(1);
  end

  assign tick = (cnt == '0);

  // a reload with a nonzero value silences the strobe in the next cycle (R8)
  assert_reload_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && load_val != '0) |=> !tick);

endmodule

// File: rtl/brg_phase_div.sv
module brg_phase_div
  import brg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  brg_mode_e mode,
  input  logic      os_tick,
  output logic      bit_tick
);

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] last;
  logic               wrap;

  assign last = last_phase(mode);
  assign wrap = (phase >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (clear)   phase <= '0;
    else if (os_tick) phase <= wrap ? '0 : phase + PHASE_W'(1);
  end

  assign bit_tick = os_tick && wrap;

  // the bit strobe is a single-cycle pulse (R9)
  assert_bit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

endmodule

// File: rtl/brg_line_clock.sv
module brg_line_clock
  import brg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  brg_mode_e mode,
  input  logic      os_tick,
  output logic      sclk
);

  always_ff @(posedge clk) begin
    if (!rst_n)                                sclk <= 1'b0;
    else if (mode != MODE_SYNC_X2 || clear)    sclk <= 1'b0;
    else if (os_tick)                          sclk <= ~sclk;
  end

  // line clock idles low outside synchronous master mode (R7)
  assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_SYNC_X2) |=> !sclk);

endmodule

// File: rtl/bitrate_gen.sv
module bitrate_gen
  import brg_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             os_tick,
  output logic             bit_tick,
  output logic             sclk_out
);

  brg_mode_e        mode_e;
  logic [DIV_W-1:0] divisor;

  assign mode_e = brg_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (!rst_n)      divisor <= '0;
    else if (div_we) divisor <= div_wdata;
  end

  brg_os_counter #(.CNT_W(DIV_W)) u_os (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (div_we),
    .load_val  (div_wdata),
    .period_m1 (divisor),
    .tick      (os_tick)
  );

  brg_phase_div u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (div_we),
    .mode     (mode_e),
    .os_tick  (os_tick),
    .bit_tick (bit_tick)
  );

  brg_line_clock u_lclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (div_we),
    .mode    (mode_e),
    .os_tick (os_tick),
    .sclk    (sclk_out)
  );

  // in sync master mode every oversample strobe flips the line clock (R6)
  assert_sclk_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == MODE_SYNC_X2 && os_tick && !div_we) |=> (sclk_out != $past(sclk_out)));

  // a bit strobe is always accompanied by an oversample strobe (R9)
  assert_bit_with_os_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

endmodule

// File: tb/sim_bitrate_gen.sv
module sim_bitrate_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        div_we = 1'b0;
  logic [11:0] div_wdata = '0;
  logic        os_tick, bit_tick, sclk_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state
  int m_n = 0, m_pc = 0, m_ph = 0, m_sclk = 0;

  always #5 clk = ~clk;

  bitrate_gen u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .div_we(div_we),
    .div_wdata(div_wdata), .os_tick(os_tick), .bit_tick(bit_tick),
    .sclk_out(sclk_out)
  );

  function automatic int factor_of(input logic [1:0] m);
    if (m == 2'b01) return 8;
    if (m == 2'b10) return 2;
    return 16;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // model update at each edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_n = 0; m_pc = 0; m_ph = 0; m_sclk = 0;
    end else begin
      int os;
      int wrap;
      os = (m_pc == 0);
      wrap = (m_ph >= factor_of(mode) - 1);
      if (mode != 2'b10 || div_we) m_sclk = 0;
      else if (os != 0)            m_sclk = 1 - m_sclk;
      if (div_we) begin
        m_n = int'(div_wdata); m_pc = m_n; m_ph = 0;
      end else if (os != 0) begin
        m_pc = m_n;
        m_ph = (wrap != 0) ? 0 : m_ph + 1;
      end else begin
        m_pc = m_pc - 1;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      int e_os;
      e_os = (m_pc == 0);
      chk("R2 os_tick model", int'(os_tick), e_os);
      chk("R3 bit_tick model", int'(bit_tick),
          ((e_os != 0) && m_ph >= factor_of(mode) - 1) ? 1 : 0);
      chk("R6 sclk model", int'(sclk_out), m_sclk);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic run_case(input logic [1:0] m, input int n, input string req);
    int f, first_os, first_bit, second_bit, toggles, prev_s;
    f = factor_of(m);
    first_os = -1; first_bit = -1; second_bit = -1; toggles = 0;
    step();
    mode = m; div_we = 1'b1; div_wdata = 12'(n);
    step();
    div_we = 1'b0;
    prev_s = int'(sclk_out);
    chk("R6 sclk low after write", prev_s, 0);
    for (int c = 0; c < 20000; c++) begin
      if (first_os < 0 && os_tick) first_os = c;
      if (int'(sclk_out) != prev_s) toggles++;
      prev_s = int'(sclk_out);
      if (bit_tick) begin
        if (first_bit < 0) first_bit = c;
        else begin second_bit = c; break; end
      end
      step();
    end
    chk("R8 first os_tick", first_os, n);
    chk("R8 first bit_tick", first_bit, f * (n + 1) - 1);
    chk(req, second_bit - first_bit, f * (n + 1));
    chk("R6 R7 sclk toggles", toggles, (m == 2'b10) ? 3 : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    step();
    // R1: state right after reset
    chk("R1 os_tick after reset", int'(os_tick), 1);
    chk("R1 bit_tick after reset", int'(bit_tick), 0);
    chk("R1 sclk after reset", int'(sclk_out), 0);
    step();
    chk("R1 os_tick with zero divisor", int'(os_tick), 1);

    run_case(2'b00, 1,   "R3 normal period N=1");
    run_case(2'b01, 1,   "R4 double period N=1");
    run_case(2'b10, 3,   "R5 sync period N=3");
    run_case(2'b11, 0,   "R3 reserved mode as normal");
    run_case(2'b00, 0,   "R3 normal period N=0");
    run_case(2'b10, 0,   "R5 sync period N=0");
    run_case(2'b01, 37,  "R4 double period N=37");
    run_case(2'b00, 100, "R3 normal period N=100");
    run_case(2'b10, 4095,"R5 sync period N=max");

    // R10: phase beyond new last phase wraps on next oversample strobe
    step();
    mode = 2'b00; div_we = 1'b1; div_wdata = 12'd0;
    step();
    div_we = 1'b0;
    repeat (6) step();
    chk("R10 no bit strobe before switch", int'(bit_tick), 0);
    mode = 2'b10;
    #1;
    chk("R10 bit strobe on switch", int'(bit_tick), 1);
    step();
    chk("R9 no back-to-back bit strobe", int'(bit_tick), 0);
    repeat (5) step();

    // R7: leaving sync mode drives the line clock low
    mode = 2'b01;
    step();
    chk("R7 sclk low outside sync", int'(sclk_out), 0);
    repeat (20) step();
    chk("R7 sclk stays low", int'(sclk_out), 0);

    // R8: write mid-count restarts timing
    mode = 2'b00; div_we = 1'b1; div_wdata = 12'd9;
    step();
    div_we = 1'b0;
    repeat (4) step();
    div_we = 1'b1; div_wdata = 12'd2;
    step();
    div_we = 1'b0;
    chk("R8 no strobe right after reload", int'(os_tick), 0);
    step(); step();
    chk("R8 strobe N cycles after reload", int'(os_tick), 1);
    repeat (10) step();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule